// File: doc/BRIEF.md
# Staged Display Power Sequencer

This block brings a parallel display interface up and takes it down again through four gated stages: the pixel clock, the sync timing, the display-enable signal and the backlight PWM. Software requests a stage on or off with single-cycle pulses. The block accepts a request only when the neighbouring stage has reached the right state, so the stages always move in a legal order. Each stage reports a status bit once it has really changed.

The pixel clock comes from a programmable divider. A configuration field holds the division ratio minus two. A bypass bit passes the system clock straight through, and a polarity bit inverts the clock that leaves the block. The display stage works on frame boundaries. After sync starts, it waits a programmable number of frame ends before the display signal rises. The timing generator supplies the frame-end strobe.

Top module: `dsp_pwr_seq`

## Requirements
- R1: After reset every stage output and every status bit is 0, and `pix_clk` rests at 0.
- R2: Stage bits are ordered bit0 pixel clock, bit1 sync, bit2 display, bit3 PWM. An on-request for the pixel clock is always accepted. An on-request for sync needs status bit0 set, for display it needs status bit1 set, and for PWM it needs status bit2 set. Otherwise the request is dropped.
- R3: An off-request for display is always accepted. An off-request for sync needs status bit2 clear, for the pixel clock it needs status bit1 clear, and for PWM it needs status bit0 clear. Otherwise the request is dropped.
- R4: If the on-request and the off-request of the same stage arrive in the same cycle, that stage is left unchanged.
- R5: When bypass is 0 and the clock stage is on, `pix_clk` has a period of `cfg_div`+2 system cycles and is high for the first floor((`cfg_div`+2)/2) cycles of each period (polarity 0). While the clock stage is off, `pix_clk` rests at the polarity level.
- R6: When bypass is 1 and the clock stage is on, `pix_clk` follows the system clock (polarity 0).
- R7: Polarity 1 inverts `pix_clk`, both while it runs and while it rests.
- R8: The pixel-clock, sync and PWM stage outputs take an accepted request at the next divider boundary. With bypass set, that is the clock edge after the edge that accepts the request.
- R9: Each bit of `stage_status` equals its stage output delayed by two clock edges.
- R10: The display output changes only on a frame end. It rises on the frame end that brings the count of frame ends since sync turned on up to the guard value, provided display is requested. It falls on the first frame end after its off-request is accepted.
- R11: Configuration is loaded when `cfg_we` is high. Reset leaves the divider field at 0, bypass at 0, polarity at 0 and the guard at 1 frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_div | input | 8 | Division ratio minus two |
| cfg_bypass | input | 1 | Use the system clock as the pixel clock |
| cfg_pol | input | 1 | Invert the pixel clock output |
| cfg_guard | input | 4 | Frame ends between sync on and display on |
| stage_on_req | input | 4 | Per-stage on pulses |
| stage_off_req | input | 4 | Per-stage off pulses |
| frame_end | input | 1 | One-cycle strobe at each frame end |
| pix_clk | output | 1 | Gated pixel clock |
| pclk_on | output | 1 | Pixel clock stage active |
| sync_en | output | 1 | Sync timing stage active |
| disp_en | output | 1 | Display enable signal |
| pwm_en | output | 1 | Backlight PWM stage active |
| stage_status | output | 4 | Synchronized per-stage status |

## Verification
With bypass set, an accepted on-request or off-request shows on the stage output two edges after the pulse is driven, and on the status bit two edges after that. A frame-end strobe moves the display output one edge after it is driven. Each stimulus task queues the old value for the cycle before the change and the new value for the cycle of the change. A monitor compares each queued value at the falling edge of exactly its due cycle, so both an early change and a late change are caught. With the divider active, the boundary depends on the divider phase. There the bench waits a bounded number of cycles and measures the clock period and duty cycle edge by edge.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;

    localparam int NSTG    = 4;
    localparam int DIV_W   = 8;
    localparam int GUARD_W = 4;

    // bit index of each stage in the stage vectors
    typedef enum logic [1:0] {
        STG_CLK  = 2'd0,
        STG_SYNC = 2'd1,
        STG_DISP = 2'd2,
        STG_PWM  = 2'd3
    } stage_e;

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               bypass;
        logic               pol;
        logic [GUARD_W-1:0] guard;
    } seq_cfg_t;

    // bring-up order: clock, sync, display, PWM
    function automatic logic on_allowed(stage_e s, logic [NSTG-1:0] st);
        case (s)
            STG_CLK:  return 1'b1;
            STG_SYNC: return st[0];
            STG_DISP: return st[1];
            default:  return st[2];
        endcase
    endfunction

    // shut-down order: display, sync, clock, PWM
    function automatic logic off_allowed(stage_e s, logic [NSTG-1:0] st);
        case (s)
            STG_DISP: return 1'b1;
            STG_SYNC: return !st[2];
            STG_CLK:  return !st[1];
            default:  return !st[0];
        endcase
    endfunction

endpackage

// File: rtl/dsp_pclk_div.sv
module dsp_pclk_div
    import dsp_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_cfg_t cfg,
    input  logic     run,
    output logic     tick,
    output logic     pix_clk
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] last_cnt;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt;
    logic          wrap;
    logic          base;
    logic          src;

    assign last_cnt = {1'b0, cfg.div} + CW'(1);
    assign half     = (last_cnt + CW'(1)) >> 1;
    assign wrap     = (cnt >= last_cnt);
    assign tick     = cfg.bypass | wrap;
    assign base     = (cnt < half);

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (cfg.bypass || wrap) cnt <= '0;
        else                         cnt <= cnt + CW'(1);
    end

    assign src     = cfg.bypass ? clk : base;
    assign pix_clk = run ? (src ^ cfg.pol) : cfg.pol;

    // ratio is at least two, so divided boundaries never fall on adjacent cycles
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cfg.bypass) |=> (!tick || cfg.bypass || !$stable(cfg)));

endmodule

// File: rtl/dsp_stage_req.sv
module dsp_stage_req
    import dsp_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSTG-1:0] on_req,
    input  logic [NSTG-1:0] off_req,
    input  logic [NSTG-1:0] stat,
    output logic [NSTG-1:0] req
);
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        logic r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= 1'b0;
            else if (on_req[g] && !off_req[g] && on_allowed(stage_e'(g), stat))
                r <= 1'b1;
            else if (off_req[g] && !on_req[g] && off_allowed(stage_e'(g), stat))
                r <= 1'b0;
        end
        assign req[g] = r;
    end

    p_sync_on_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(req[1]) |-> $past(stat[0]));
    p_disp_on_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(req[2]) |-> $past(stat[1]));
    p_pwm_on_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(req[3]) |-> $past(stat[2]));
    p_sync_off_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(req[1]) |-> !$past(stat[2]));
    p_clk_off_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(req[0]) |-> !$past(stat[1]));
    p_both_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (on_req[0] && off_req[0]) |=> $stable(req[0]));

endmodule

// File: rtl/dsp_stage_ack.sv
module dsp_stage_ack
    import dsp_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               frame_end,
    input  logic [GUARD_W-1:0] guard,
    input  logic [NSTG-1:0]    req,
    output logic [NSTG-1:0]    act
);
    logic [GUARD_W-1:0] fcnt;
    logic [GUARD_W:0]   fnext;

    assign fnext = {1'b0, fcnt} + (GUARD_W+1)'(1);

    // frame ends counted since sync became active, saturating
    always_ff @(posedge clk) begin
        if (rst || !act[1])                fcnt <= '0;
        else if (frame_end && fcnt != '1)  fcnt <= fcnt + GUARD_W'(1);
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_ack
        logic a;
        if (g == int'(STG_DISP)) begin : g_frame
            always_ff @(posedge clk) begin
                if (rst)
                    a <= 1'b0;
                else if (frame_end) begin
                    if (req[g] && act[1] && fnext >= {1'b0, guard}) a <= 1'b1;
                    else if (!req[g])                                a <= 1'b0;
                end
            end
        end else begin : g_tick
            always_ff @(posedge clk) begin
                if (rst)       a <= 1'b0;
                else if (tick) a <= req[g];
            end
        end
        assign act[g] = a;
    end

    p_disp_on_frame_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(act[2]) || $fell(act[2])) |-> $past(frame_end));
    p_disp_after_sync_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(act[2]) |-> $past(act[1]));
    p_sync_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(act[1]) || $fell(act[1])) |-> $past(tick));

endmodule

// File: rtl/dsp_stat_sync.sv
module dsp_stat_sync
    import dsp_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSTG-1:0] act,
    output logic [NSTG-1:0] stat
);
    logic [NSTG-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            stat <= '0;
        end else begin
            meta <= act;
            stat <= meta;
        end
    end

    p_stat_lag_r9: assert property (@(posedge clk) disable iff (rst)
        stat == $past(act, 2));

endmodule

// File: rtl/dsp_pwr_seq.sv
module dsp_pwr_seq
    import dsp_seq_pkg::*;
#(
    parameter int GUARD_INIT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_bypass,
    input  logic               cfg_pol,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic [NSTG-1:0]    stage_on_req,
    input  logic [NSTG-1:0]    stage_off_req,
    input  logic               frame_end,
    output logic               pix_clk,
    output logic               pclk_on,
    output logic               sync_en,
    output logic               disp_en,
    output logic               pwm_en,
    output logic [NSTG-1:0]    stage_status
);
    seq_cfg_t        cfg_q;
    logic [NSTG-1:0] req;
    logic [NSTG-1:0] act;
    logic            tick;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{div: '0, bypass: 1'b0, pol: 1'b0, guard: GUARD_W'(GUARD_INIT)};
        else if (cfg_we)
            cfg_q <= '{div: cfg_div, bypass: cfg_bypass, pol: cfg_pol, guard: cfg_guard};
    end

    dsp_stage_req u_req (
        .clk     (clk),
        .rst     (rst),
        .on_req  (stage_on_req),
        .off_req (stage_off_req),
        .stat    (stage_status),
        .req     (req)
    );

    dsp_pclk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .run     (act[STG_CLK]),
        .tick    (tick),
        .pix_clk (pix_clk)
    );

    dsp_stage_ack u_ack (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_end (frame_end),
        .guard     (cfg_q.guard),
        .req       (req),
        .act       (act)
    );

    dsp_stat_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .stat (stage_status)
    );

    assign pclk_on = act[STG_CLK];
    assign sync_en = act[STG_SYNC];
    assign disp_en = act[STG_DISP];
    assign pwm_en  = act[STG_PWM];

    p_disp_needs_sync_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_en) |-> sync_en);

endmodule

// File: tb/tb_dsp_pwr_seq.sv
module tb_dsp_pwr_seq;
    import dsp_seq_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst;
    logic               cfg_we;
    logic [DIV_W-1:0]   cfg_div;
    logic               cfg_bypass;
    logic               cfg_pol;
    logic [GUARD_W-1:0] cfg_guard;
    logic [NSTG-1:0]    on_req;
    logic [NSTG-1:0]    off_req;
    logic               frame_end;
    logic               pix_clk, pclk_on, sync_en, disp_en, pwm_en;
    logic [NSTG-1:0]    stage_status;

    dsp_pwr_seq dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_bypass(cfg_bypass), .cfg_pol(cfg_pol), .cfg_guard(cfg_guard),
        .stage_on_req(on_req), .stage_off_req(off_req), .frame_end(frame_end),
        .pix_clk(pix_clk), .pclk_on(pclk_on), .sync_en(sync_en),
        .disp_en(disp_en), .pwm_en(pwm_en), .stage_status(stage_status)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        int         sel;
        logic [3:0] val;
        string      tag;
    } exp_t;
    exp_t q[$];
    logic [3:0] cur = 4'b0000;

    function automatic logic [3:0] obs(int sel);
        case (sel)
            0:       return stage_status;
            1:       return {pwm_en, disp_en, sync_en, pclk_on};
            default: return {3'b000, pix_clk};
        endcase
    endfunction

    task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // monitor: compare every queued item in its due cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                chk(q[i].tag, obs(q[i].sel), q[i].val);
                q.delete(i);
            end
        end
    end

    // driver: one-cycle stimulus, expected outputs pushed to the scoreboard
    task automatic step(logic [3:0] on_m, logic [3:0] off_m, logic fr,
                        int lat, logic [3:0] nv, string tag);
        int k;
        @(posedge clk); #1;
        k = cyc;
        q.push_back('{k + lat - 1, 1, cur, tag});
        q.push_back('{k + lat,     1, nv,  tag});
        q.push_back('{k + lat + 1, 0, cur, "R9"});
        q.push_back('{k + lat + 2, 0, nv,  "R9"});
        on_req = on_m; off_req = off_m; frame_end = fr;
        @(posedge clk); #1;
        on_req = '0; off_req = '0; frame_end = 1'b0;
        cur = nv;
        repeat (lat + 2) @(posedge clk);
        #1;
    endtask

    task automatic pulse(logic [3:0] on_m, logic [3:0] off_m);
        @(posedge clk); #1;
        on_req = on_m; off_req = off_m;
        @(posedge clk); #1;
        on_req = '0; off_req = '0;
    endtask

    task automatic poll(int sel, logic [3:0] mask, logic [3:0] val, int lim, string tag);
        logic ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if ((obs(sel) & mask) == val) begin
                ok = 1'b1;
                break;
            end
        end
        chk(tag, obs(sel) & mask, val);
        if (!ok) $display("  (%s: value not reached within %0d cycles)", tag, lim);
    endtask

    task automatic measure(int n_exp, int hi_exp, string tag);
        logic prev, seen;
        int   per, hi;
        seen = 1'b0;
        @(negedge clk);
        prev = pix_clk;
        for (int i = 0; i < 50 && !seen; i++) begin
            @(negedge clk);
            if (pix_clk && !prev) seen = 1'b1;
            prev = pix_clk;
        end
        per = 0;
        hi  = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            per++;
            if (pix_clk && !prev) break;
            if (pix_clk) hi++;
            prev = pix_clk;
        end
        chk({tag, " period"}, 4'(per), 4'(n_exp));
        chk({tag, " high"},   4'(hi),  4'(hi_exp));
    endtask

    task automatic cfg_write(int dv, logic byp, logic pl, int gd);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_div = DIV_W'(dv); cfg_bypass = byp;
        cfg_pol = pl; cfg_guard = GUARD_W'(gd);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_div = '0; cfg_bypass = 1'b0;
        cfg_pol = 1'b0; cfg_guard = '0; on_req = '0; off_req = '0; frame_end = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 status", stage_status, 4'b0000);
        chk("R1 outputs", obs(1), 4'b0000);
        chk("R1 pix_clk", obs(2), 4'b0000);

        // reset configuration: ratio 2, guard of one frame
        pulse(4'b0001, 4'b0000);
        poll(1, 4'b0001, 4'b0001, 10, "R8 clk on");
        poll(0, 4'b0001, 4'b0001, 10, "R9 clk status");
        measure(2, 1, "R5 ratio2");
        pulse(4'b0010, 4'b0000);
        poll(1, 4'b0010, 4'b0010, 10, "R8 sync on");
        poll(0, 4'b0010, 4'b0010, 10, "R9 sync status");
        pulse(4'b0100, 4'b0000);
        cur = 4'b0011;
        step(4'b0000, 4'b0000, 1'b1, 1, 4'b0111, "R11 default guard");
        step(4'b0000, 4'b0100, 1'b0, 2, 4'b0111, "R10 disp waits frame");
        step(4'b0000, 4'b0000, 1'b1, 1, 4'b0011, "R10 disp off");
        pulse(4'b0000, 4'b0010);
        poll(1, 4'b0010, 4'b0000, 10, "R8 sync off");
        poll(0, 4'b0010, 4'b0000, 10, "R9 sync status off");
        pulse(4'b0000, 4'b0001);
        poll(1, 4'b1111, 4'b0000, 10, "R8 clk off");
        poll(0, 4'b1111, 4'b0000, 10, "R9 all off");
        cur = 4'b0000;

        // bypass, guard of three frames: exact timing
        cfg_write(3, 1'b1, 1'b0, 3);
        step(4'b0010, 4'b0000, 1'b0, 2, 4'b0000, "R2 sync ignored");
        step(4'b0100, 4'b0000, 1'b0, 2, 4'b0000, "R2 disp ignored");
        step(4'b1000, 4'b0000, 1'b0, 2, 4'b0000, "R2 pwm ignored");
        step(4'b0001, 4'b0000, 1'b0, 2, 4'b0001, "R8 clk on bypass");
        step(4'b0100, 4'b0000, 1'b0, 2, 4'b0001, "R2 disp before sync");
        step(4'b0010, 4'b0000, 1'b0, 2, 4'b0011, "R8 sync on bypass");
        step(4'b0000, 4'b0001, 1'b0, 2, 4'b0011, "R3 clk off ignored");
        step(4'b0100, 4'b0000, 1'b0, 2, 4'b0011, "R10 disp held for frame");
        step(4'b0000, 4'b0000, 1'b1, 1, 4'b0011, "R10 guard frame1");
        step(4'b0000, 4'b0000, 1'b1, 1, 4'b0011, "R10 guard frame2");
        step(4'b0000, 4'b0000, 1'b1, 1, 4'b0111, "R10 guard frame3");
        step(4'b1000, 4'b0000, 1'b0, 2, 4'b1111, "R2 pwm on");
        step(4'b0000, 4'b0010, 1'b0, 2, 4'b1111, "R3 sync off ignored");
        step(4'b0000, 4'b1000, 1'b0, 2, 4'b1111, "R3 pwm off ignored");
        step(4'b0000, 4'b0100, 1'b0, 2, 4'b1111, "R10 disp off waits");
        step(4'b0000, 4'b0000, 1'b1, 1, 4'b1011, "R10 disp off frame");
        step(4'b0000, 4'b0010, 1'b0, 2, 4'b1001, "R3 sync off");
        step(4'b0000, 4'b0001, 1'b0, 2, 4'b1000, "R3 clk off");
        step(4'b0000, 4'b1000, 1'b0, 2, 4'b0000, "R3 pwm off");
        step(4'b0001, 4'b0001, 1'b0, 2, 4'b0000, "R4 both same cycle");

        // divided clock with inverted polarity
        cfg_write(3, 1'b0, 1'b1, 3);
        @(negedge clk);
        chk("R7 idle level", obs(2), 4'b0001);
        pulse(4'b0001, 4'b0000);
        poll(1, 4'b0001, 4'b0001, 10, "R8 clk on ratio5");
        measure(5, 3, "R7 ratio5 inverted");
        cfg_write(3, 1'b0, 1'b0, 3);
        measure(5, 2, "R5 ratio5");

        // bypass: pixel clock follows the system clock
        cfg_write(3, 1'b1, 1'b0, 3);
        @(posedge clk); #1;
        chk("R6 high phase", obs(2), 4'b0001);
        @(negedge clk); #1;
        chk("R6 low phase", obs(2), 4'b0000);

        repeat (6) @(posedge clk);
        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R9 scoreboard actual=%0d expected=0 items left", q.size());
        end
        summary();
        $finish;
    end

endmodule